// File: doc/BRIEF.md
# Per-CPU Private Interrupt Configuration Register Bank

This block holds the configuration state of the 32 private interrupts of one processor: 16 software-generated and 16 peripheral. It sits behind a simple request/response register port that carries byte, word and doubleword accesses, each tagged secure or non-secure. Every register access passes through a security filter. When security is enabled, a non-secure requester sees and changes only the interrupts whose group bit is 1. Priorities are presented to such a requester through a shifted view. A global security-disable input turns this filtering off.

Each request is answered exactly one cycle later with read data and an error flag. The error flag is raised for offsets that map to no register and for access sizes the target does not support. Signalling, prioritisation and the delivery of interrupts are handled by neighbouring logic, which reads the state kept here. The bank reads the current line levels only to form the pending view.

Top module: `pirq_cfg_bank`

## Requirements
- R1: A request with `req_valid` high gets `rsp_valid` high in the next cycle with its read data and error flag. A write, or any request that errors, returns zero data.
- R2: `rsp_err` is set in these cases: size code 3; a byte access outside the priority window 0x200-0x21F; a word access that is not 4-byte aligned or that hits no register; a doubleword access anywhere other than 0x008, 0x018 or 0x020. Size codes are 0 = byte, 1 = word, 2 = doubleword.
- R3: When `req_secure`=0 and `sec_disable`=0, the enable, pending and active registers and the trigger words show and change only bits whose group bit (register 0x080) is 1. In every other case all bits are accessible.
- R4: These offsets form set/clear pairs: enable 0x100/0x104, pending 0x108/0x10C, active 0x110/0x114. The set offset ORs in the masked write data and the clear offset removes it. Both offsets of a pair read the same value.
- R5: A filtered (non-secure, security enabled) read of a group-1 priority returns the stored byte shifted left by one and truncated to 8 bits. A filtered write of that priority stores 0x80 | (data >> 1).
- R6: A filtered access to a group-0 priority reads zero and leaves the stored byte unchanged.
- R7: A word access at 0x200 + 4k covers interrupts 4k to 4k+3, with the lowest-numbered interrupt in bits 7:0. A byte access at 0x200 + n covers interrupt n only.
- R8: Reading the pending register returns the latched pending bits ORed with `irq_level` for every interrupt whose edge bit is 0.
- R9: The trigger word at 0x180 reads edge bits 0-15, and the trigger word at 0x184 reads edge bits 16-31. Edge bit i of the half appears at data bit 2i+1, and the even bits read 0. Writes to 0x180 are ignored. A write to 0x184 loads data bit 2i+1 into edge bit 16+i, under the R3 mask.
- R10: The group-modifier register (0x084) and the access-control register (0x088) read zero and ignore writes unless `req_secure`=1 and `sec_disable`=0.
- R11: The group register (0x080) reads zero and ignores writes when `req_secure`=0 and `sec_disable`=0.
- R12: In the wake register (0x010), bit 0 takes bit 0 of the write data and bit 1 becomes the same value on the same write. All other bits read 0.
- R13: Two 64-bit base registers, at 0x018 and 0x020, accept doubleword writes or word writes to either half; the high half is at +4. The identification register at 0x008/0x00C returns `TYPE_VALUE` and ignores writes. Control (0x000) and status (0x004) read zero and ignore writes.
- R14: Reset clears every stored register to zero and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Global security-disable; 1 lifts all filtering |
| irq_level | input | 32 | Current input level per interrupt, used by the pending view |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 invalid |
| req_addr | input | 12 | Byte offset in the bank |
| req_wdata | input | 64 | Write data, right-aligned |
| req_secure | input | 1 | 1 = secure requester |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Error response |

## Verification
The hardest case to reach is a filtered priority write. Whether it lands depends on the group bit of each individual byte lane, and a lane that does land is rewritten into the offset encoding. The stimulus first gives group 1 to a mixed set of interrupts through a secure access. It then issues non-secure byte and word accesses that straddle group-0 and group-1 lanes, and reads each lane back both securely and non-securely. The level-triggered part of the pending view is reached by holding `irq_level` steady and then switching an interrupt to edge mode, which removes that interrupt's level from the pending readback.

// File: rtl/pirq_cfg_pkg.sv
package pirq_cfg_pkg;

    localparam int NIRQ      = 32;
    localparam int IDX_W     = $clog2(NIRQ);
    localparam int PRIO_W    = 8;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 64;
    localparam int WORD_W    = 32;
    localparam int HALF_IRQ  = NIRQ / 2;
    localparam int NBITMAP   = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_TYPE   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_WAKE   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_PROP   = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_GROUP  = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_GMOD   = 12'h084;
    localparam logic [ADDR_W-1:0] OFF_NSAC   = 12'h088;
    localparam logic [ADDR_W-1:0] OFF_ENS    = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_ENC    = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_PDS    = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_PDC    = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_ACS    = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_ACC    = 12'h114;
    localparam logic [ADDR_W-1:0] OFF_CFG0   = 12'h180;
    localparam logic [ADDR_W-1:0] OFF_CFG1   = 12'h184;
    localparam logic [ADDR_W-1:0] OFF_PRIO   = 12'h200;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_CTRL, SEL_STAT, SEL_TYPE, SEL_WAKE,
        SEL_PROP, SEL_PEND, SEL_GROUP, SEL_GMOD, SEL_NSAC,
        SEL_ENS, SEL_ENC, SEL_PDS, SEL_PDC, SEL_ACS, SEL_ACC,
        SEL_CFG0, SEL_CFG1, SEL_PRIO
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic              hi;
        logic [IDX_W-1:0]  pidx;
        logic              err;
    } dec_t;

    // edge bit i goes to bit 2i+1
    function automatic logic [WORD_W-1:0] spread_odd(input logic [HALF_IRQ-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < HALF_IRQ; i++) r[2*i+1] = v[i];
        return r;
    endfunction

    function automatic logic [HALF_IRQ-1:0] gather_odd(input logic [WORD_W-1:0] v);
        logic [HALF_IRQ-1:0] r;
        for (int i = 0; i < HALF_IRQ; i++) r[i] = v[2*i+1];
        return r;
    endfunction

endpackage

// File: rtl/pirq_cfg_decode.sv
module pirq_cfg_decode
    import pirq_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    logic [ADDR_W-1:0] prio_off;
    logic              in_prio;

    assign prio_off = addr - OFF_PRIO;
    assign in_prio  = (addr >= OFF_PRIO) && (prio_off < ADDR_W'(NIRQ));

    always_comb begin
        dec      = '0;
        dec.sel  = SEL_NONE;
        dec.err  = 1'b1;
        dec.pidx = prio_off[IDX_W-1:0];
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                if (in_prio) begin
                    dec.sel = SEL_PRIO;
                    dec.err = 1'b0;
                end
            end
            SZ_WORD: begin
                if (addr[1:0] == 2'b00) begin
                    dec.err = 1'b0;
                    case (addr)
                        OFF_CTRL:      dec.sel = SEL_CTRL;
                        OFF_STAT:      dec.sel = SEL_STAT;
                        OFF_TYPE:      dec.sel = SEL_TYPE;
                        OFF_TYPE + 4:  begin dec.sel = SEL_TYPE; dec.hi = 1'b1; end
                        OFF_WAKE:      dec.sel = SEL_WAKE;
                        OFF_PROP:      dec.sel = SEL_PROP;
                        OFF_PROP + 4:  begin dec.sel = SEL_PROP; dec.hi = 1'b1; end
                        OFF_PEND:      dec.sel = SEL_PEND;
                        OFF_PEND + 4:  begin dec.sel = SEL_PEND; dec.hi = 1'b1; end
                        OFF_GROUP:     dec.sel = SEL_GROUP;
                        OFF_GMOD:      dec.sel = SEL_GMOD;
                        OFF_NSAC:      dec.sel = SEL_NSAC;
                        OFF_ENS:       dec.sel = SEL_ENS;
                        OFF_ENC:       dec.sel = SEL_ENC;
                        OFF_PDS:       dec.sel = SEL_PDS;
                        OFF_PDC:       dec.sel = SEL_PDC;
                        OFF_ACS:       dec.sel = SEL_ACS;
                        OFF_ACC:       dec.sel = SEL_ACC;
                        OFF_CFG0:      dec.sel = SEL_CFG0;
                        OFF_CFG1:      dec.sel = SEL_CFG1;
                        default: begin
                            if (in_prio) dec.sel = SEL_PRIO;
                            else         dec.err = 1'b1;
                        end
                    endcase
                end
            end
            SZ_DWORD: begin
                dec.err = 1'b0;
                case (addr)
                    OFF_TYPE: dec.sel = SEL_TYPE;
                    OFF_PROP: dec.sel = SEL_PROP;
                    OFF_PEND: dec.sel = SEL_PEND;
                    default:  dec.err = 1'b1;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pirq_cfg_bitmap.sv
module pirq_cfg_bitmap
    import pirq_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] wdata,
    input  logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] q
);
    logic [NIRQ-1:0] eff;
    assign eff = wdata & mask;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (set_we) q <= q | eff;
        else if (clr_we) q <= q & ~eff;
    end

    // R4: a set-type write never drops a bit
    a_r4_set_only_adds: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(q)) == $past(q)));

    // R4: a clear-type write never raises a bit
    a_r4_clear_only_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((q | $past(q)) == $past(q)));

endmodule

// File: rtl/pirq_cfg_prio.sv
module pirq_cfg_prio
    import pirq_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              filtered,
    input  logic [NIRQ-1:0]   group,
    output logic [WORD_W-1:0] rdata
);
    logic [PRIO_W-1:0] prio_q [NIRQ];
    logic [PRIO_W-1:0] view   [NIRQ];

    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);
        logic              hit;
        logic              allow;
        logic [PRIO_W-1:0] lane;
        logic [PRIO_W-1:0] nxt;

        assign hit   = wr && (word ? (ME[IDX_W-1:2] == idx[IDX_W-1:2]) : (ME == idx));
        assign allow = !filtered || group[i];
        assign lane  = word ? wdata[ME[1:0]*PRIO_W +: PRIO_W] : wdata[PRIO_W-1:0];
        assign nxt   = filtered ? ({1'b1, {(PRIO_W-1){1'b0}}} | (lane >> 1)) : lane;

        always_ff @(posedge clk) begin
            if (rst)                prio_q[i] <= '0;
            else if (hit && allow)  prio_q[i] <= nxt;
        end

        always_comb begin
            if (!filtered)     view[i] = prio_q[i];
            else if (group[i]) view[i] = {prio_q[i][PRIO_W-2:0], 1'b0};
            else               view[i] = '0;
        end

        // R6: a filtered write leaves a group-0 priority untouched
        a_r6_hidden_prio_kept: assert property (@(posedge clk) disable iff (rst)
            (hit && filtered && !group[i]) |=> $stable(prio_q[i]));

        // R5: a filtered write to a group-1 priority sets the top bit
        a_r5_ns_write_topbit: assert property (@(posedge clk) disable iff (rst)
            (hit && filtered && group[i]) |=> prio_q[i][PRIO_W-1]);
    end

    always_comb begin
        if (word) begin
            for (int b = 0; b < 4; b++)
                rdata[b*PRIO_W +: PRIO_W] = view[{idx[IDX_W-1:2], 2'(b)}];
        end else begin
            rdata = {{(WORD_W-PRIO_W){1'b0}}, view[idx]};
        end
    end

endmodule

// File: rtl/pirq_cfg_bank.sv
module pirq_cfg_bank
    import pirq_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TYPE_VALUE = 64'h0000_0100_0000_0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_disable,
    input  logic [NIRQ-1:0]   irq_level,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int BM_EN = 0;
    localparam int BM_PD = 1;
    localparam int BM_AC = 2;

    dec_t              dec;
    logic              wr;
    logic              filtered;
    logic              full_secure;
    logic [NIRQ-1:0]   mask;
    logic [WORD_W-1:0] wd;

    logic [NIRQ-1:0]   group_q;
    logic [NIRQ-1:0]   gmod_q;
    logic [WORD_W-1:0] nsac_q;
    logic [NIRQ-1:0]   edge_q;
    logic [1:0]        wake_q;
    logic [DATA_W-1:0] base_q [2];

    logic [NIRQ-1:0]   bm_q   [NBITMAP];
    logic [NBITMAP-1:0] bm_set;
    logic [NBITMAP-1:0] bm_clr;

    logic [WORD_W-1:0] prio_rd;
    logic [NIRQ-1:0]   edge_m;
    logic [DATA_W-1:0] rd;

    pirq_cfg_decode u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign wr          = req_valid && req_write && !dec.err;
    assign filtered    = !req_secure && !sec_disable;
    assign full_secure = req_secure && !sec_disable;
    assign mask        = filtered ? group_q : '1;
    assign wd          = req_wdata[WORD_W-1:0];

    assign bm_set[BM_EN] = wr && (dec.sel == SEL_ENS);
    assign bm_clr[BM_EN] = wr && (dec.sel == SEL_ENC);
    assign bm_set[BM_PD] = wr && (dec.sel == SEL_PDS);
    assign bm_clr[BM_PD] = wr && (dec.sel == SEL_PDC);
    assign bm_set[BM_AC] = wr && (dec.sel == SEL_ACS);
    assign bm_clr[BM_AC] = wr && (dec.sel == SEL_ACC);

    for (genvar k = 0; k < NBITMAP; k++) begin : g_bm
        pirq_cfg_bitmap u_bm (
            .clk    (clk),
            .rst    (rst),
            .set_we (bm_set[k]),
            .clr_we (bm_clr[k]),
            .wdata  (wd),
            .mask   (mask),
            .q      (bm_q[k])
        );
    end

    pirq_cfg_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr && (dec.sel == SEL_PRIO)),
        .word     (req_size == SZ_WORD),
        .idx      (dec.pidx),
        .wdata    (wd),
        .filtered (filtered),
        .group    (group_q),
        .rdata    (prio_rd)
    );

    // configuration words, wake and group state
    always_ff @(posedge clk) begin
        if (rst) begin
            group_q <= '0;
            gmod_q  <= '0;
            nsac_q  <= '0;
            edge_q  <= '0;
            wake_q  <= '0;
        end else if (wr) begin
            unique case (dec.sel)
                SEL_GROUP: if (!filtered) group_q <= wd;
                SEL_GMOD:  if (full_secure) gmod_q <= wd;
                SEL_NSAC:  if (full_secure) nsac_q <= wd;
                SEL_WAKE:  wake_q <= {wd[0], wd[0]};
                SEL_CFG1:  edge_q[NIRQ-1:HALF_IRQ] <=
                               (edge_q[NIRQ-1:HALF_IRQ] & ~mask[NIRQ-1:HALF_IRQ]) |
                               (gather_odd(wd) & mask[NIRQ-1:HALF_IRQ]);
                default: ;
            endcase
        end
    end

    // 64-bit base registers
    for (genvar b = 0; b < 2; b++) begin : g_base
        localparam reg_sel_e MY_SEL = (b == 0) ? SEL_PROP : SEL_PEND;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[b] <= '0;
            end else if (wr && (dec.sel == MY_SEL)) begin
                if (req_size == SZ_DWORD) base_q[b] <= req_wdata;
                else if (dec.hi)          base_q[b][DATA_W-1:WORD_W] <= wd;
                else                      base_q[b][WORD_W-1:0] <= wd;
            end
        end
    end

    function automatic logic [DATA_W-1:0] pick64(input logic [DATA_W-1:0] v,
                                                 input logic dw, input logic hi);
        if (dw)      return v;
        else if (hi) return {{WORD_W{1'b0}}, v[DATA_W-1:WORD_W]};
        else         return {{WORD_W{1'b0}}, v[WORD_W-1:0]};
    endfunction

    assign edge_m = edge_q & mask;

    always_comb begin
        rd = '0;
        unique case (dec.sel)
            SEL_TYPE:  rd = pick64(TYPE_VALUE, req_size == SZ_DWORD, dec.hi);
            SEL_PROP:  rd = pick64(base_q[0], req_size == SZ_DWORD, dec.hi);
            SEL_PEND:  rd = pick64(base_q[1], req_size == SZ_DWORD, dec.hi);
            SEL_WAKE:  rd = DATA_W'(wake_q);
            SEL_GROUP: rd = filtered ? '0 : DATA_W'(group_q);
            SEL_GMOD:  rd = full_secure ? DATA_W'(gmod_q) : '0;
            SEL_NSAC:  rd = full_secure ? DATA_W'(nsac_q) : '0;
            SEL_ENS, SEL_ENC: rd = DATA_W'(bm_q[BM_EN] & mask);
            SEL_PDS, SEL_PDC: rd = DATA_W'((bm_q[BM_PD] | (~edge_q & irq_level)) & mask);
            SEL_ACS, SEL_ACC: rd = DATA_W'(bm_q[BM_AC] & mask);
            SEL_CFG0:  rd = DATA_W'(spread_odd(edge_m[HALF_IRQ-1:0]));
            SEL_CFG1:  rd = DATA_W'(spread_odd(edge_m[NIRQ-1:HALF_IRQ]));
            SEL_PRIO:  rd = DATA_W'(prio_rd);
            default:   rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write && !dec.err) ? rd : '0;
        end
    end

    // R1: every request is answered in the following cycle
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        (!rst && req_valid) |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        (!rst && !req_valid) |=> !rsp_valid);

    // R2: size code 3 always errors
    a_r2_bad_size_err: assert property (@(posedge clk) disable iff (rst)
        (!rst && req_valid && req_size == 2'd3) |=> (rsp_err && rsp_rdata == '0));

    // R11: group register hidden from filtered reads
    a_r11_group_hidden: assert property (@(posedge clk) disable iff (rst)
        (!rst && req_valid && !req_write && dec.sel == SEL_GROUP && filtered)
        |=> (rsp_rdata == '0));

    // R12: asleep status tracks the sleep request immediately
    a_r12_wake_pair: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr && dec.sel == SEL_WAKE)
        |=> (wake_q == {$past(req_wdata[0]), $past(req_wdata[0])}));

endmodule

// File: tb/pirq_cfg_bank_tb.sv
module pirq_cfg_bank_tb;
    import pirq_cfg_pkg::*;

    localparam logic [63:0] TV = 64'h0000_0100_0000_0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_dis = 1'b0;
    logic [31:0] lvl = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_secure = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;

    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] exp_d [$];
    logic        exp_e [$];
    string       exp_t [$];

    always #10 clk = ~clk;

    pirq_cfg_bank #(.TYPE_VALUE(TV)) u_dut (
        .clk (clk), .rst (rst), .sec_disable (sec_dis), .irq_level (lvl),
        .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_secure (req_secure),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err)
    );

    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                        input logic [63:0] wd, input logic sec,
                        input logic [63:0] exp, input logic eerr, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz;
        req_addr   = a;
        req_wdata  = wd;
        req_secure = sec;
        exp_d.push_back((wr || eerr) ? 64'h0 : exp);
        exp_e.push_back(eerr);
        exp_t.push_back(tag);
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d, input logic sec, input string tag);
        xfer(1'b1, 2'd1, a, {32'h0, d}, sec, 64'h0, 1'b0, tag);
    endtask

    task automatic rd32(input logic [11:0] a, input logic sec, input logic [31:0] e, input string tag);
        xfer(1'b0, 2'd1, a, 64'h0, sec, {32'h0, e}, 1'b0, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_d.size() == 0) begin
                chk(1'b0, "R1 unexpected response", {63'h0, rsp_valid}, 64'h0);
            end else begin
                logic [63:0] ed;
                logic        ee;
                string       et;
                ed = exp_d.pop_front();
                ee = exp_e.pop_front();
                et = exp_t.pop_front();
                chk(rsp_rdata == ed, {et, " data"}, rsp_rdata, ed);
                chk(rsp_err == ee, {et, " err"}, {63'h0, rsp_err}, {63'h0, ee});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R14 rsp_valid in reset", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;
        // R14: cleared state
        rd32(12'h080, 1'b1, 32'h0, "R14 group after reset");
        rd32(12'h200, 1'b1, 32'h0, "R14 prio after reset");
        rd32(12'h108, 1'b1, 32'h0, "R14 pending after reset");
        rd32(12'h010, 1'b1, 32'h0, "R14 wake after reset");
        xfer(1'b0, 2'd2, 12'h018, 64'h0, 1'b1, 64'h0, 1'b0, "R14 base after reset");

        // R11 group register
        wr32(12'h080, 32'h0000_FF0F, 1'b1, "R11 secure group write");
        rd32(12'h080, 1'b0, 32'h0, "R11 ns group read hidden");
        wr32(12'h080, 32'hFFFF_FFFF, 1'b0, "R11 ns group write");
        rd32(12'h080, 1'b1, 32'h0000_FF0F, "R11 ns group write ignored");

        // R3/R4 enable pair
        wr32(12'h100, 32'hFFFF_FFFF, 1'b0, "R3 ns enable set");
        rd32(12'h104, 1'b1, 32'h0000_FF0F, "R3 R4 masked set, clr addr readback");
        wr32(12'h100, 32'h00F0_0000, 1'b1, "R4 secure enable set");
        rd32(12'h100, 1'b0, 32'h0000_FF0F, "R3 ns enable view masked");
        wr32(12'h104, 32'hFFFF_FFFF, 1'b0, "R3 ns enable clear");
        rd32(12'h100, 1'b1, 32'h00F0_0000, "R3 R4 clear kept group-0 bits");

        // R8/R9 pending and trigger
        @(negedge clk);
        req_valid = 1'b0;
        lvl = 32'h0001_0002;
        rd32(12'h108, 1'b1, 32'h0001_0002, "R8 level-triggered lines in pending");
        wr32(12'h108, 32'h8000_0000, 1'b1, "R4 pending set");
        rd32(12'h10C, 1'b1, 32'h8001_0002, "R8 R4 latch or level");
        wr32(12'h184, 32'h0000_0002, 1'b1, "R9 cfg1 write irq16 edge");
        rd32(12'h108, 1'b1, 32'h8000_0002, "R8 edge irq drops level");
        rd32(12'h184, 1'b1, 32'h0000_0002, "R9 cfg1 readback");
        wr32(12'h180, 32'hFFFF_FFFF, 1'b1, "R9 cfg0 write");
        rd32(12'h180, 1'b1, 32'h0, "R9 cfg0 ignores writes");
        wr32(12'h184, 32'hAAAA_AAAA, 1'b0, "R9 ns cfg1 write");
        rd32(12'h184, 1'b1, 32'h0000_0002, "R9 R3 ns cfg1 masked out");
        rd32(12'h184, 1'b0, 32'h0, "R9 R3 ns cfg1 view");
        wr32(12'h10C, 32'h8000_0000, 1'b1, "R4 pending clear");
        rd32(12'h108, 1'b1, 32'h0000_0002, "R4 pending after clear");

        // active pair
        wr32(12'h110, 32'h0000_0011, 1'b1, "R4 active set");
        rd32(12'h114, 1'b0, 32'h0000_0001, "R3 ns active view");
        wr32(12'h114, 32'hFFFF_FFFF, 1'b0, "R3 ns active clear");
        rd32(12'h110, 1'b1, 32'h0000_0010, "R3 R4 active after ns clear");

        // R5/R6/R7 priorities
        wr32(12'h200, 32'h4433_2211, 1'b1, "R7 word prio write");
        xfer(1'b0, 2'd0, 12'h202, 64'h0, 1'b1, 64'h33, 1'b0, "R7 byte prio read irq2");
        xfer(1'b1, 2'd0, 12'h201, 64'h40, 1'b0, 64'h0, 1'b0, "R5 ns byte write irq1");
        xfer(1'b0, 2'd0, 12'h201, 64'h0, 1'b1, 64'hA0, 1'b0, "R5 stored ns encoding");
        xfer(1'b0, 2'd0, 12'h201, 64'h0, 1'b0, 64'h40, 1'b0, "R5 ns shifted view");
        rd32(12'h200, 1'b1, 32'h4433_A011, "R7 byte write touched one lane");
        wr32(12'h204, 32'hFFFF_FFFF, 1'b0, "R6 ns word write group0");
        rd32(12'h204, 1'b1, 32'h0, "R6 group0 prio unchanged");
        xfer(1'b1, 2'd0, 12'h204, 64'h55, 1'b1, 64'h0, 1'b0, "R7 secure byte write irq4");
        rd32(12'h204, 1'b0, 32'h0, "R6 group0 prio reads zero");
        rd32(12'h204, 1'b1, 32'h0000_0055, "R7 irq4 in low byte");
        rd32(12'h200, 1'b0, 32'h8866_4022, "R5 ns word view");

        // R10
        wr32(12'h084, 32'h1234_5678, 1'b1, "R10 gmod write");
        rd32(12'h084, 1'b1, 32'h1234_5678, "R10 gmod secure read");
        rd32(12'h084, 1'b0, 32'h0, "R10 gmod ns read");
        wr32(12'h084, 32'h0, 1'b0, "R10 gmod ns write");
        rd32(12'h084, 1'b1, 32'h1234_5678, "R10 gmod ns write ignored");
        wr32(12'h088, 32'hDEAD_BEEF, 1'b1, "R10 access write");
        rd32(12'h088, 1'b1, 32'hDEAD_BEEF, "R10 access secure read");
        rd32(12'h088, 1'b0, 32'h0, "R10 access ns read");

        // R12
        wr32(12'h010, 32'hFFFF_FFFF, 1'b1, "R12 wake set");
        rd32(12'h010, 1'b1, 32'h3, "R12 wake both bits");
        wr32(12'h010, 32'h0000_0002, 1'b0, "R12 wake bit1 only");
        rd32(12'h010, 1'b1, 32'h0, "R12 bit1 not writable");

        // R13
        xfer(1'b1, 2'd2, 12'h018, 64'h1122_3344_5566_7788, 1'b1, 64'h0, 1'b0, "R13 dword base write");
        xfer(1'b0, 2'd2, 12'h018, 64'h0, 1'b1, 64'h1122_3344_5566_7788, 1'b0, "R13 dword base read");
        rd32(12'h01C, 1'b0, 32'h1122_3344, "R13 high half word read");
        wr32(12'h020, 32'hAAAA_5555, 1'b1, "R13 low half write");
        wr32(12'h024, 32'h0F0F_0F0F, 1'b1, "R13 high half write");
        xfer(1'b0, 2'd2, 12'h020, 64'h0, 1'b1, 64'h0F0F_0F0F_AAAA_5555, 1'b0, "R13 halves combined");
        xfer(1'b1, 2'd2, 12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 1'b0, "R13 type write");
        xfer(1'b0, 2'd2, 12'h008, 64'h0, 1'b1, TV, 1'b0, "R13 type read-only");
        rd32(12'h00C, 1'b1, TV[63:32], "R13 type high word");
        wr32(12'h000, 32'hFFFF_FFFF, 1'b1, "R13 control write");
        rd32(12'h000, 1'b1, 32'h0, "R13 control reads zero");
        wr32(12'h004, 32'hFFFF_FFFF, 1'b1, "R13 status write");
        rd32(12'h004, 1'b1, 32'h0, "R13 status reads zero");

        // R2 errors
        xfer(1'b0, 2'd3, 12'h080, 64'h0, 1'b1, 64'h0, 1'b1, "R2 size code 3");
        xfer(1'b0, 2'd0, 12'h080, 64'h0, 1'b1, 64'h0, 1'b1, "R2 byte outside prio");
        xfer(1'b0, 2'd1, 12'h300, 64'h0, 1'b1, 64'h0, 1'b1, "R2 unmapped word");
        xfer(1'b0, 2'd2, 12'h080, 64'h0, 1'b1, 64'h0, 1'b1, "R2 dword to word reg");
        xfer(1'b0, 2'd1, 12'h082, 64'h0, 1'b1, 64'h0, 1'b1, "R2 misaligned word");
        xfer(1'b1, 2'd0, 12'h220, 64'h7, 1'b1, 64'h0, 1'b1, "R2 byte past prio window");

        // security disabled
        idle(1);
        sec_dis = 1'b1;
        rd32(12'h080, 1'b0, 32'h0000_FF0F, "R11 ns group visible when disabled");
        rd32(12'h084, 1'b1, 32'h0, "R10 gmod zero when disabled");
        rd32(12'h100, 1'b0, 32'h00F0_0000, "R3 full ns view when disabled");
        xfer(1'b0, 2'd0, 12'h201, 64'h0, 1'b0, 64'hA0, 1'b0, "R5 no shift when disabled");

        // reset again
        idle(3);
        sec_dis = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(rsp_valid == 1'b0, "R14 rsp_valid in second reset", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;
        rd32(12'h080, 1'b1, 32'h0, "R14 group cleared");
        rd32(12'h200, 1'b1, 32'h0, "R14 prio cleared");
        rd32(12'h010, 1'b1, 32'h0, "R14 wake cleared");
        idle(3);
        chk(exp_d.size() == 0, "R1 missing responses", 64'(exp_d.size()), 64'h0);
        finish_run();
    end

endmodule